// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is a small file of configuration bytes that sits behind two I/O addresses. The host first writes a register number to the select port, then reads or writes the chosen register through the data port. Only a scattered set of register numbers exists: a single DMA control byte, a run of sixteen general bytes and a run of five more. The block passes the contents of every byte to neighbouring logic, and it splits the DMA byte into named fields for the DMA timing and clock selection logic.

The select is good for exactly one data-port access. After that access the host has to select again. Until it does, data writes have no effect and data reads return all ones. A data access to a register number that does not exist is treated in the same way. It also uses up the select.

Top module: `cfg_index_port`

## Requirements
- R1: After reset no register is selected, every register holds 00h, and all DMA field outputs are 0.
- R2: Writing a register number to the select port (22h) and then writing the data port (23h) stores the data byte in that register. The new value appears on `cfg_regs_flat` from the clock after the write strobe. Slot s occupies bits [8s+7:8s], where slot 0 is number 01h, slots 1 to 16 are 40h to 4Fh, and slots 17 to 21 are 60h to 64h.
- R3: A data-port read after a select returns the selected register on `io_rdata` during the cycle the read strobe is high.
- R4: A data-port access uses up the select. A second data write without a new select changes nothing, and a second data read returns FFh.
- R5: A data access to a register number that does not exist changes no register, and a read returns FFh.
- R6: The only register numbers that exist are 01h, 40h to 4Fh and 60h to 64h. Numbers such as 00h, 02h, 3Fh, 50h, 5Fh and 65h do not exist.
- R7: The DMA byte (01h) drives its fields out as follows: bits 5:4 go to `dma_ws16`, bits 3:2 go to `dma_ws8`, bit 1 goes to `dma_memr_early`, and bit 0 goes to `dma_clk_full`.
- R8: Bits 7:6 of the DMA byte are reserved. They are never stored, and they read as 0.
- R9: A write to any address other than 22h or 23h changes no register and leaves the select as it was. A read from any address other than 23h returns 00h.
- R10: A new select that arrives before a data access replaces the pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W (16) | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational during the read strobe) |
| cfg_regs_flat | output | 8*NREG (176) | All register contents, one byte per slot |
| dma_ws16 | output | 2 | Wait-state code for 16-bit DMA |
| dma_ws8 | output | 2 | Wait-state code for 8-bit DMA |
| dma_memr_early | output | 1 | Memory-read strobe starts together with the I/O read |
| dma_clk_full | output | 1 | DMA clock runs at the full bus clock rate |

## Verification
The bench builds the block with its default map: the DMA byte at 01h, a run of sixteen at 40h and a run of five at 60h, which gives 22 slots. With this map, both edges of each run and the numbers just outside them can be reached directly. The bench also uses the select at 22h and the data port at 23h, so the neighbouring addresses 21h and 24h can be tried as ports that must have no effect. Random select numbers are drawn partly from the implemented set and partly from the whole byte range. This mixes hits, misses and stale accesses on every slot.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
   localparam int DATA_W = 8;
   typedef logic [DATA_W-1:0] cfg_byte_t;

   localparam cfg_byte_t RD_MISS     = 8'hFF;
   localparam cfg_byte_t RD_IDLE     = 8'h00;
   localparam cfg_byte_t DMA_WMASK   = 8'h3F;
   localparam cfg_byte_t FULL_WMASK  = 8'hFF;
   localparam cfg_byte_t REG_RST_VAL = 8'h00;

   function automatic cfg_byte_t slot_wmask(input int slot);
      return (slot == 0) ? DMA_WMASK : FULL_WMASK;
   endfunction
endpackage

// File: rtl/cfg_index_latch.sv
module cfg_index_latch
   import cfg_port_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sel_we,
   input  cfg_byte_t sel_din,
   input  logic      consume,
   output cfg_byte_t sel_q,
   output logic      sel_valid
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q     <= '0;
         sel_valid <= 1'b0;
      end else if (sel_we) begin
         sel_q     <= sel_din;
         sel_valid <= 1'b1;
      end else if (consume) begin
         sel_valid <= 1'b0;
      end
   end

   AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      sel_we |=> (sel_valid && sel_q == $past(sel_din)));   // R10
   AST_SEL_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
      (consume && !sel_we) |=> !sel_valid);                   // R4
endmodule

// File: rtl/cfg_index_decode.sv
module cfg_index_decode
   import cfg_port_pkg::*;
#(
   parameter cfg_byte_t DMA_IDX     = 8'h01,
   parameter cfg_byte_t BANK_A_BASE = 8'h40,
   parameter int        BANK_A_CNT  = 16,
   parameter cfg_byte_t BANK_B_BASE = 8'h60,
   parameter int        BANK_B_CNT  = 5,
   parameter int        SLOT_W      = 5
)(
   input  cfg_byte_t         sel,
   output logic              hit,
   output logic [SLOT_W-1:0] slot
);
   localparam int A_LO = int'(BANK_A_BASE);
   localparam int A_HI = A_LO + BANK_A_CNT - 1;
   localparam int B_LO = int'(BANK_B_BASE);
   localparam int B_HI = B_LO + BANK_B_CNT - 1;
   localparam int D_IX = int'(DMA_IDX);

   generate
      if (BANK_A_CNT < 1 || BANK_B_CNT < 1)
         $error("cfg_index_decode: each run needs at least one register");
      if (A_HI > 255 || B_HI > 255)
         $error("cfg_index_decode: run exceeds the 8-bit select range");
      if (!(A_HI < B_LO || B_HI < A_LO))
         $error("cfg_index_decode: runs overlap");
      if ((D_IX >= A_LO && D_IX <= A_HI) || (D_IX >= B_LO && D_IX <= B_HI))
         $error("cfg_index_decode: DMA number collides with a run");
   endgenerate

   always_comb begin
      int s;
      s   = 0;
      hit = 1'b0;
      if (int'(sel) == D_IX) begin
         hit = 1'b1;
         s   = 0;
      end else if (int'(sel) >= A_LO && int'(sel) <= A_HI) begin
         hit = 1'b1;
         s   = 1 + int'(sel) - A_LO;
      end else if (int'(sel) >= B_LO && int'(sel) <= B_HI) begin
         hit = 1'b1;
         s   = 1 + BANK_A_CNT + int'(sel) - B_LO;
      end
      slot = SLOT_W'(s);
   end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
   import cfg_port_pkg::*;
#(
   parameter int NREG   = 22,
   parameter int SLOT_W = 5
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [SLOT_W-1:0]      slot,
   input  cfg_byte_t              wdata,
   output cfg_byte_t              rdata,
   output logic [NREG*DATA_W-1:0] regs_flat
);
   generate
      if (NREG > (1 << SLOT_W))
         $error("cfg_reg_bank: SLOT_W too narrow for NREG");
   endgenerate

   cfg_byte_t regs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_slot
      localparam cfg_byte_t WMASK = slot_wmask(g);
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[g] <= REG_RST_VAL;
         else if (we && int'(slot) == g)
            regs[g] <= wdata & WMASK;
      end
      assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
   end

   always_comb begin
      rdata = RD_MISS;
      for (int i = 0; i < NREG; i++)
         if (int'(slot) == i) rdata = regs[i];
   end

   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(regs_flat));                                      // R5
   AST_DMA_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && slot == '0) |=> (regs_flat[DATA_W-1:DATA_W-2] == 2'b00));  // R8
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
   import cfg_port_pkg::*;
#(
   parameter int          ADDR_W      = 16,
   parameter logic [15:0] SEL_PORT    = 16'h0022,
   parameter logic [15:0] DATA_PORT   = 16'h0023,
   parameter cfg_byte_t   DMA_IDX     = 8'h01,
   parameter cfg_byte_t   BANK_A_BASE = 8'h40,
   parameter int          BANK_A_CNT  = 16,
   parameter cfg_byte_t   BANK_B_BASE = 8'h60,
   parameter int          BANK_B_CNT  = 5,
   localparam int         NREG        = 1 + BANK_A_CNT + BANK_B_CNT
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      io_addr,
   input  logic                   io_wr,
   input  logic                   io_rd,
   input  logic [7:0]             io_wdata,
   output logic [7:0]             io_rdata,
   output logic [NREG*8-1:0]      cfg_regs_flat,
   output logic [1:0]             dma_ws16,
   output logic [1:0]             dma_ws8,
   output logic                   dma_memr_early,
   output logic                   dma_clk_full
);
   localparam int SLOT_W = (NREG > 1) ? $clog2(NREG) : 1;

   generate
      if (ADDR_W < 2 || ADDR_W > 16)
         $error("cfg_index_port: ADDR_W out of range");
      if (SEL_PORT == DATA_PORT)
         $error("cfg_index_port: select and data ports must differ");
   endgenerate

   logic              sel_we, data_wr, data_rd, consume;
   cfg_byte_t         sel_q;
   logic              sel_valid;
   logic              hit;
   logic [SLOT_W-1:0] slot;
   logic              bank_we;
   cfg_byte_t         bank_rd;

   assign sel_we  = io_wr && (io_addr == ADDR_W'(SEL_PORT));
   assign data_wr = io_wr && (io_addr == ADDR_W'(DATA_PORT));
   assign data_rd = io_rd && !io_wr && (io_addr == ADDR_W'(DATA_PORT));
   assign consume = data_wr || data_rd;

   cfg_index_latch u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_we    (sel_we),
      .sel_din   (io_wdata),
      .consume   (consume),
      .sel_q     (sel_q),
      .sel_valid (sel_valid)
   );

   cfg_index_decode #(
      .DMA_IDX     (DMA_IDX),
      .BANK_A_BASE (BANK_A_BASE),
      .BANK_A_CNT  (BANK_A_CNT),
      .BANK_B_BASE (BANK_B_BASE),
      .BANK_B_CNT  (BANK_B_CNT),
      .SLOT_W      (SLOT_W)
   ) u_dec (
      .sel  (sel_q),
      .hit  (hit),
      .slot (slot)
   );

   assign bank_we = data_wr && sel_valid && hit;

   cfg_reg_bank #(
      .NREG   (NREG),
      .SLOT_W (SLOT_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (bank_we),
      .slot      (slot),
      .wdata     (io_wdata),
      .rdata     (bank_rd),
      .regs_flat (cfg_regs_flat)
   );

   always_comb begin
      if (!data_rd)
         io_rdata = RD_IDLE;
      else if (sel_valid && hit)
         io_rdata = bank_rd;
      else
         io_rdata = RD_MISS;
   end

   assign dma_ws16       = cfg_regs_flat[5:4];
   assign dma_ws8        = cfg_regs_flat[3:2];
   assign dma_memr_early = cfg_regs_flat[1];
   assign dma_clk_full   = cfg_regs_flat[0];

   AST_STALE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !sel_valid) |-> (io_rdata == RD_MISS));               // R4
   AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !hit) |=> $stable(cfg_regs_flat));                    // R5
   AST_OTHER_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_we && !consume) |=> ($stable(sel_valid) && $stable(sel_q))); // R9
endmodule

// File: tb/cfg_index_port_bench.sv
module cfg_index_port_bench;
   localparam int NREG = 22;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [15:0]       io_addr = '0;
   logic              io_wr = 1'b0;
   logic              io_rd = 1'b0;
   logic [7:0]        io_wdata = '0;
   logic [7:0]        io_rdata;
   logic [NREG*8-1:0] cfg_regs_flat;
   logic [1:0]        dma_ws16, dma_ws8;
   logic              dma_memr_early, dma_clk_full;

   int errors = 0;
   int checks = 0;

   logic [7:0] m_reg [NREG];
   logic       m_valid;
   logic [7:0] m_sel;

   always #10 clk = ~clk;

   cfg_index_port u_cfg_index_port (
      .clk            (clk),
      .rst_n          (rst_n),
      .io_addr        (io_addr),
      .io_wr          (io_wr),
      .io_rd          (io_rd),
      .io_wdata       (io_wdata),
      .io_rdata       (io_rdata),
      .cfg_regs_flat  (cfg_regs_flat),
      .dma_ws16       (dma_ws16),
      .dma_ws8        (dma_ws8),
      .dma_memr_early (dma_memr_early),
      .dma_clk_full   (dma_clk_full)
   );

   function automatic int ref_slot(input logic [7:0] n);
      if (n == 8'h01) return 0;
      if (n >= 8'h40 && n <= 8'h4F) return 1 + int'(n) - 'h40;
      if (n >= 8'h60 && n <= 8'h64) return 17 + int'(n) - 'h60;
      return -1;
   endfunction

   function automatic logic [7:0] ref_mask(input int s);
      return (s == 0) ? 8'h3F : 8'hFF;
   endfunction

   function automatic logic [NREG*8-1:0] ref_flat();
      logic [NREG*8-1:0] f;
      for (int i = 0; i < NREG; i++) f[i*8 +: 8] = m_reg[i];
      return f;
   endfunction

   task automatic chk(input logic [255:0] act, input logic [255:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
      int s;
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
      if (a == 16'h0022) begin
         m_sel = d; m_valid = 1'b1;
      end else if (a == 16'h0023) begin
         s = ref_slot(m_sel);
         if (m_valid && s >= 0) m_reg[s] = d & ref_mask(s);
         m_valid = 1'b0;
      end
   endtask

   task automatic do_rd(input logic [15:0] a, input string req);
      logic [7:0] exp;
      int s;
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #2;
      if (a == 16'h0023) begin
         s   = ref_slot(m_sel);
         exp = (m_valid && s >= 0) ? m_reg[s] : 8'hFF;
         m_valid = 1'b0;
      end else begin
         exp = 8'h00;
      end
      chk(256'(io_rdata), 256'(exp), req);
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic chk_regs(input string req);
      #1;
      chk(256'(cfg_regs_flat), 256'(ref_flat()), req);
   endtask

   initial begin
      #3_000_000;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] miss [6];
      miss = '{8'h00, 8'h02, 8'h3F, 8'h50, 8'h5F, 8'h65};
      void'($urandom(32'd4242));
      for (int i = 0; i < NREG; i++) m_reg[i] = 8'h00;
      m_valid = 1'b0; m_sel = 8'h00;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk_regs("R1 regs");
      chk(256'({dma_ws16, dma_ws8, dma_memr_early, dma_clk_full}), 256'(0), "R1 dma");
      do_rd(16'h0023, "R1 no select reads FF");

      // R7 R8: DMA byte with reserved bits set
      do_wr(16'h0022, 8'h01);
      do_wr(16'h0023, 8'hFF);
      chk_regs("R8 stored");
      chk(256'({dma_ws16, dma_ws8, dma_memr_early, dma_clk_full}), 256'(6'h3F), "R7 all ones");
      do_wr(16'h0023, 8'h00);   // R4 stale write ignored
      chk_regs("R4 stale write");
      do_rd(16'h0023, "R4 stale read");
      do_wr(16'h0022, 8'h01);
      do_rd(16'h0023, "R8 read 3F");
      do_wr(16'h0022, 8'h01);
      do_wr(16'h0023, 8'b1010_0110);
      chk(256'({dma_ws16, dma_ws8, dma_memr_early, dma_clk_full}), 256'(6'b10_01_1_0), "R7 fields");

      // R5 R6: absent numbers
      for (int k = 0; k < 6; k++) begin
         do_wr(16'h0022, miss[k]);
         do_wr(16'h0023, 8'h5A);
         chk_regs("R6 absent write");
         do_wr(16'h0022, miss[k]);
         do_rd(16'h0023, "R5 absent read");
      end

      // R2 R3 R6: run edges
      do_wr(16'h0022, 8'h40); do_wr(16'h0023, 8'h11); chk_regs("R2 40h");
      do_wr(16'h0022, 8'h4F); do_wr(16'h0023, 8'h22); chk_regs("R2 4Fh");
      do_wr(16'h0022, 8'h60); do_wr(16'h0023, 8'h33); chk_regs("R2 60h");
      do_wr(16'h0022, 8'h64); do_wr(16'h0023, 8'h44); chk_regs("R2 64h");
      do_wr(16'h0022, 8'h4F); do_rd(16'h0023, "R3 read 4Fh");
      do_wr(16'h0022, 8'h64); do_rd(16'h0023, "R3 read 64h");

      // R10: second select replaces first
      do_wr(16'h0022, 8'h40);
      do_wr(16'h0022, 8'h61);
      do_wr(16'h0023, 8'h99);
      chk_regs("R10 replaced");

      // R9: other ports
      do_wr(16'h0022, 8'h42);
      do_wr(16'h0024, 8'h77);
      do_wr(16'h0021, 8'h78);
      chk_regs("R9 other write");
      do_rd(16'h0022, "R9 read select port");
      do_rd(16'h0023, "R9 select kept");

      // random mix
      for (int n = 0; n < 400; n++) begin
         int op;
         logic [7:0] sel;
         op  = int'($urandom_range(0, 9));
         sel = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255))
               : (($urandom_range(0, 1) == 0) ? 8'(8'h40 + $urandom_range(0, 15))
                                               : 8'(8'h60 + $urandom_range(0, 4)));
         if ($urandom_range(0, 9) == 0) sel = 8'h01;
         case (op)
            0, 1, 2: do_wr(16'h0022, sel);
            3, 4:    begin do_wr(16'h0023, 8'($urandom)); chk_regs("R2 random write"); end
            5, 6:    do_rd(16'h0023, "R3 random read");
            7:       begin do_wr(16'h0022, sel); do_wr(16'h0023, 8'($urandom)); chk_regs("R2 random pair"); end
            8:       begin do_wr(16'h0025, 8'($urandom)); chk_regs("R9 random other"); end
            default: begin do_wr(16'h0022, sel); do_rd(16'h0023, "R3 random pair read"); end
         endcase
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule